// File: doc/BRIEF.md
# PCM Bit-Clock Rate Detector

This block identifies the rate of an incoming PCM bit clock when the device is a slave on a PCM bus. Working in the system clock domain, it synchronises the bit clock and the 8 kHz frame sync. It counts rising bit-clock edges from one rising frame-sync edge to the next and matches that count against nine supported bus rates, from 256 kHz up to 4.096 MHz. The set covers both T1-style rates (1.544 and 3.088 MHz) and E1-style rates (2.048 MHz).

A rate is reported only after the same recognised count has been seen over several frames in a row. A count outside the table, or a count that differs from the previous frame, drops the lock and clears the code. A mismatch flag tells the surrounding logic why.

When detection is switched off, the code becomes a plain register that software may load. The detector keeps no state across a disable.

Top module: `pcmRateDetect`

## Requirements
- R1: After reset, rateCode is 0000, rateLocked is 0 and rateMismatch is 0.
- R2: A frame count maps to rateCode as follows: 32→1, 64→2, 96→3, 128→4, 192→5, 193→6, 256→7, 386→8, 512→9. The frame count is the number of rising bit-clock edges between two rising frame-sync edges.
- R3: rateLocked rises, and rateCode shows the mapped value, when the third consecutive evaluated frame gives the same recognised count. Until then rateCode reads 0000 and rateLocked reads 0.
- R4: An evaluated frame whose count is not in the R2 table sets rateMismatch to 1, clears rateLocked and returns rateCode to 0000.
- R5: A recognised count that differs from the previous frame's count sets rateMismatch, clears rateLocked and rateCode, and restarts the three-frame agreement.
- R6: The bit counter saturates at 2^CNT_W−1 (1023 by default). A frame that is too long is therefore treated as unrecognised.
- R7: The first rising frame-sync edge after enable, or after reset, only starts a count. It evaluates nothing and leaves all outputs unchanged.
- R8: While detectEn is 0, rateLocked and rateMismatch read 0 and frames have no effect. rateCode holds its value, and a pulse on swWrEn loads swCode into rateCode.
- R9: While detectEn is 1, swWrEn has no effect on rateCode.
- R10: rateMismatch is updated only when a frame is evaluated and holds between evaluations. A repeated recognised count gives rateMismatch 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pcmClk | input | 1 | PCM bit clock (asynchronous) |
| frameSync | input | 1 | 8 kHz frame sync (asynchronous) |
| detectEn | input | 1 | 1 enables automatic detection |
| swWrEn | input | 1 | Software load strobe for rateCode |
| swCode | input | 4 | Value loaded by swWrEn while disabled |
| rateCode | output | 4 | Detected rate code, 0000 when none |
| rateLocked | output | 1 | Valid rate detected |
| rateMismatch | output | 1 | Last evaluated frame was unrecognised or changed |

## Verification
The hardest situations to reach from the ports are the saturated counter and a count change between two recognised rates while locked. Both need long, exactly shaped frames. The bench builds every frame from a task that emits a frame-sync pulse followed by an exact number of bit-clock pulses, several system cycles apart. This lets it produce an over-long 1100-bit frame and a lock on 64 followed by 128 bits. A bench model of the agreement rule predicts each outcome one frame later, when the next frame sync evaluates it.

// File: rtl/pcmRateDetPkg.sv
package pcmRateDetPkg;
  localparam int CODE_W    = 4;
  localparam int NUM_RATES = 9;
  // bit clocks per 8 kHz frame, index i yields code i+1
  localparam int unsigned RATE_COUNTS [NUM_RATES] = '{32, 64, 96, 128, 192, 193, 256, 386, 512};

  typedef struct packed {
    logic flush;      // detection disabled: drop all frame history
    logic restart;    // frame boundary: restart the bit counter
    logic latchPrev;  // frame evaluated: keep its count for comparison
  } ctrlStrobes_t;

  function automatic logic [CODE_W-1:0] rateCodeOf(input int unsigned cnt);
    logic [CODE_W-1:0] code;
    code = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (cnt == RATE_COUNTS[i]) code = CODE_W'(i + 1);
    end
    return code;
  endfunction
endpackage

// File: rtl/pcmRateSync.sv
module pcmRateSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/pcmRateDatapath.sv
module pcmRateDatapath
  import pcmRateDetPkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pcmClk,
  input  logic              frameSync,
  input  ctrlStrobes_t      st,
  output logic              fsRise,
  output logic [CODE_W-1:0] countCode,
  output logic              sameCount,
  output logic              prevValid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             bitRise;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] prevCnt;

  pcmRateSync #(.STAGES(SYNC_STAGES)) bitSync_i (
    .clk(clk), .rstN(rstN), .din(pcmClk), .rise(bitRise));
  pcmRateSync #(.STAGES(SYNC_STAGES)) fsSync_i (
    .clk(clk), .rstN(rstN), .din(frameSync), .rise(fsRise));

  // bit clocks seen since the last frame-sync edge, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            bitCnt <= '0;
    else if (st.flush)                    bitCnt <= '0;
    else if (st.restart)                  bitCnt <= bitRise ? CNT_W'(1) : '0;
    else if (bitRise && bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCnt   <= '0;
      prevValid <= 1'b0;
    end else if (st.flush) begin
      prevValid <= 1'b0;
    end else if (st.latchPrev) begin
      prevCnt   <= bitCnt;
      prevValid <= 1'b1;
    end
  end

  assign countCode = rateCodeOf(32'(bitCnt));
  assign sameCount = prevValid && (bitCnt == prevCnt);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == CNT_MAX) && !st.restart && !st.flush |=> bitCnt == CNT_MAX);
  // R10
  prev_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.latchPrev && !st.flush |=> $stable(prevCnt));
endmodule

// File: rtl/pcmRateCtrl.sv
module pcmRateCtrl
  import pcmRateDetPkg::*;
#(
  parameter int LOCK_FRAMES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              detectEn,
  input  logic              swWrEn,
  input  logic [CODE_W-1:0] swCode,
  input  logic              fsRise,
  input  logic [CODE_W-1:0] countCode,
  input  logic              sameCount,
  input  logic              prevValid,
  output ctrlStrobes_t      st,
  output logic [CODE_W-1:0] rateCode,
  output logic              rateLocked,
  output logic              rateMismatch
);
  localparam int AGREE_W = $clog2(LOCK_FRAMES + 1);
  localparam logic [AGREE_W-1:0] LOCK_CNT = AGREE_W'(LOCK_FRAMES);

  logic               armed;
  logic [AGREE_W-1:0] agree;
  logic [AGREE_W-1:0] agreeNext;
  logic               evalNow;
  logic               recognized;

  assign evalNow    = detectEn && fsRise && armed;
  assign recognized = (countCode != '0);

  always_comb begin
    if (recognized && sameCount)
      agreeNext = (agree >= LOCK_CNT) ? LOCK_CNT : agree + 1'b1;
    else
      agreeNext = recognized ? AGREE_W'(1) : '0;
  end

  always_comb begin
    st.flush     = !detectEn;
    st.restart   = detectEn && fsRise;
    st.latchPrev = evalNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed        <= 1'b0;
      agree        <= '0;
      rateLocked   <= 1'b0;
      rateMismatch <= 1'b0;
      rateCode     <= '0;
    end else if (!detectEn) begin
      armed        <= 1'b0;
      agree        <= '0;
      rateLocked   <= 1'b0;
      rateMismatch <= 1'b0;
      if (swWrEn) rateCode <= swCode;
    end else if (fsRise) begin
      if (!armed) begin
        armed <= 1'b1;
      end else begin
        agree        <= agreeNext;
        rateLocked   <= (agreeNext >= LOCK_CNT);
        rateCode     <= (agreeNext >= LOCK_CNT) ? countCode : '0;
        rateMismatch <= !recognized || (prevValid && !sameCount);
      end
    end
  end

  // R3
  locked_has_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    rateLocked |-> rateCode != '0);
  // R8
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !detectEn |=> !rateLocked && !rateMismatch);
  // R9
  sw_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    detectEn && swWrEn && !fsRise |=> $stable(rateCode));
  // R7
  arm_no_eval_chk: assert property (@(posedge clk) disable iff (!rstN)
    detectEn && fsRise && !armed |=> !rateLocked && $stable(rateCode) && $stable(rateMismatch));
  // R10
  mismatch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    detectEn && !fsRise |=> $stable(rateMismatch));
endmodule

// File: rtl/pcmRateDetect.sv
module pcmRateDetect
  import pcmRateDetPkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_FRAMES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pcmClk,
  input  logic       frameSync,
  input  logic       detectEn,
  input  logic       swWrEn,
  input  logic [3:0] swCode,
  output logic [3:0] rateCode,
  output logic       rateLocked,
  output logic       rateMismatch
);
  ctrlStrobes_t      st;
  logic              fsRise;
  logic [CODE_W-1:0] countCode;
  logic              sameCount;
  logic              prevValid;

  pcmRateDatapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .pcmClk(pcmClk), .frameSync(frameSync), .st(st),
    .fsRise(fsRise), .countCode(countCode), .sameCount(sameCount), .prevValid(prevValid));

  pcmRateCtrl #(.LOCK_FRAMES(LOCK_FRAMES)) ctrl_i (
    .clk(clk), .rstN(rstN), .detectEn(detectEn), .swWrEn(swWrEn), .swCode(swCode),
    .fsRise(fsRise), .countCode(countCode), .sameCount(sameCount), .prevValid(prevValid),
    .st(st), .rateCode(rateCode), .rateLocked(rateLocked), .rateMismatch(rateMismatch));
endmodule

// File: tb/pcmRateDetect_tb_top.sv
module pcmRateDetect_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pcmClk = 1'b0;
  logic frameSync = 1'b0;
  logic detectEn = 1'b1;
  logic swWrEn = 1'b0;
  logic [3:0] swCode = 4'd0;
  logic [3:0] rateCode;
  logic rateLocked;
  logic rateMismatch;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  pcmRateDetect dut_i (
    .clk(clk), .rstN(rstN), .pcmClk(pcmClk), .frameSync(frameSync),
    .detectEn(detectEn), .swWrEn(swWrEn), .swCode(swCode),
    .rateCode(rateCode), .rateLocked(rateLocked), .rateMismatch(rateMismatch));

  typedef struct {
    logic [3:0] code;
    logic       lock;
    logic       mis;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  event sampleEv;

  // bench model state, built from the requirements
  int  rateTab [9] = '{32, 64, 96, 128, 192, 193, 256, 386, 512};
  logic [3:0] expCode = 4'd0;
  bit  expLock = 1'b0;
  bit  expMis = 1'b0;
  bit  mEn = 1'b1;
  bit  mArmed = 1'b0;
  bit  mPrevValid = 1'b0;
  int  mPrevN = 0;
  int  mAgree = 0;
  int  mLastN = 0;

  function automatic int mapCode(int n);
    int c = 0;
    for (int i = 0; i < 9; i++) if (rateTab[i] == n) c = i + 1;
    return c;
  endfunction

  task automatic pushCheck(string tag);
    expItem_t it;
    it.code = expCode; it.lock = expLock; it.mis = expMis; it.tag = tag;
    expQ.push_back(it);
    ->sampleEv;
  endtask

  // monitor: pops expected items and compares at the ports
  initial begin
    forever begin
      expItem_t it;
      @(sampleEv);
      it = expQ.pop_front();
      checks += 3;
      if (rateCode !== it.code) begin
        errors++;
        $display("FAIL %s rateCode actual=%0d expected=%0d", it.tag, rateCode, it.code);
      end
      if (rateLocked !== it.lock) begin
        errors++;
        $display("FAIL %s rateLocked actual=%0b expected=%0b", it.tag, rateLocked, it.lock);
      end
      if (rateMismatch !== it.mis) begin
        errors++;
        $display("FAIL %s rateMismatch actual=%0b expected=%0b", it.tag, rateMismatch, it.mis);
      end
    end
  end

  // driver: frame-sync pulse (evaluates previous frame) then n bit clocks
  task automatic runFrame(int n);
    string tag;
    if (!mEn) begin
      tag = "R8";
    end else if (!mArmed) begin
      mArmed = 1'b1;
      tag = "R7";
    end else begin
      int cnt = (mLastN > 1023) ? 1023 : mLastN;
      int c = mapCode(cnt);
      bit rec = (c != 0);
      bit same = mPrevValid && (cnt == mPrevN);
      if (mLastN > 1023)               tag = "R6";
      else if (!rec)                   tag = "R4";
      else if (mPrevValid && !same)    tag = "R5";
      else if (mAgree + 1 >= 3)        tag = "R2 R3 R10";
      else                             tag = "R3 R10";
      if (rec && same) mAgree = (mAgree >= 3) ? 3 : mAgree + 1;
      else             mAgree = rec ? 1 : 0;
      expMis  = !rec || (mPrevValid && !same);
      mPrevN = cnt;
      mPrevValid = 1'b1;
      expLock = (mAgree >= 3);
      expCode = expLock ? 4'(c) : 4'd0;
    end
    @(negedge clk);
    frameSync = 1'b1;
    pcmClk = 1'b0;
    repeat (4) @(negedge clk);
    pushCheck(tag);
    frameSync = 1'b0;
    for (int i = 0; i < n; i++) begin
      pcmClk = 1'b1;
      repeat (2) @(negedge clk);
      pcmClk = 1'b0;
      repeat (2) @(negedge clk);
    end
    mLastN = n;
  endtask

  task automatic setEn(bit v);
    @(negedge clk);
    detectEn = v;
    mEn = v;
    if (!v) begin
      mArmed = 1'b0; mAgree = 0; mPrevValid = 1'b0;
      expLock = 1'b0; expMis = 1'b0;
    end
    @(negedge clk);
    pushCheck(v ? "R7" : "R8");
  endtask

  task automatic swWrite(logic [3:0] v);
    @(negedge clk);
    swWrEn = 1'b1;
    swCode = v;
    @(negedge clk);
    swWrEn = 1'b0;
    if (!mEn) expCode = v;
    pushCheck(mEn ? "R9" : "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    pushCheck("R1");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    pushCheck("R1");

    // every table rate, three agreeing frames each (R2, R3)
    foreach (rateTab[k]) begin
      for (int j = 0; j < 3; j++) runFrame(rateTab[k]);
    end
    // unrecognised and saturating frames (R4, R6)
    runFrame(200);
    runFrame(200);
    runFrame(1100);
    // relock on 64, then an unrecognised 65 (R4)
    for (int j = 0; j < 4; j++) runFrame(64);
    runFrame(65);
    for (int j = 0; j < 4; j++) runFrame(64);
    // change between two recognised rates while locked (R5)
    for (int j = 0; j < 4; j++) runFrame(128);
    // disabled: software load, frames ignored (R8)
    setEn(1'b0);
    swWrite(4'd5);
    runFrame(96);
    runFrame(96);
    // enabled: software write ignored (R9), first sync only arms (R7)
    setEn(1'b1);
    swWrite(4'd7);
    for (int j = 0; j < 4; j++) runFrame(96);
    runFrame(32);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule